// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one timer channel for a peripheral bus. Software programs it through a small word-indexed register port. The channel holds a down-counter, a reload limit, a control byte and an interrupt flag. A clock-enable input `tick_en` paces the counter. A prescaler can thin that input so the counter steps once per 1, 16 or 256 pulses.

The counter works in one of three modes, each at a width of 16 or 32 bits. In free-running mode it wraps over the full range. In periodic mode it reloads from the stored limit. In one-shot mode it stops at zero. Each time the count reaches zero, the raw interrupt flag is set. The level output `irq` is that flag gated by the interrupt-enable bit. Software can change the limit in two ways: with an immediate restart, or with the new value held back until the next natural reload.

Top module: `ivt_channel`

## Requirements
- R1: After reset the control byte reads 0x20 (counter stopped, interrupt enable set), the limit reads 0, the current value reads 0x0000FFFF, and the raw flag, masked status and `irq` are all 0.
- R2: Word indices: 0 immediate load, 1 current value, 2 control, 3 flag clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 deferred load. Indices 0 and 6 both read back the stored limit. Control reads back in bits 7:0.
- R3: The counter steps only while control bit 7 is 1. Control bits 3:2 pick the step rate: 0 or 3 steps on every `tick_en` pulse, 1 on every 16th pulse, 2 on every 256th pulse. Any control write restarts the prescale phase.
- R4: When control bits 0 and 6 are both 0, the counter runs free. Any reload, including one caused by a load write, uses 0xFFFF or 0xFFFFFFFF, and the stored limit is ignored.
- R5: With bit 6 set and bit 0 clear (periodic), a step taken at zero reloads the counter from the limit.
- R6: With bit 0 set (one-shot), the counter stays at zero and raises no further flag until a load write or an enabling control write.
- R7: A step that takes the counter from 1 to 0 sets the raw flag.
- R8: Any write to index 3 clears the raw flag. If a flag-setting step happens in the same cycle, the set wins.
- R9: Writes to index 1 and to the unused indices 4, 5 and 7 change nothing. Index 3 and index 7 read 0.
- R10: A write to index 0 stores the limit and reloads the counter in the following cycle.
- R11: A write to index 6 stores the limit without touching the current count. The new value is used at the next reload.
- R12: `irq` and the masked status both equal the raw flag ANDed with control bit 5.
- R13: A control write with bit 7 set reloads the counter under the new mode. A control write with bit 7 clear freezes the count at its present value.
- R14: Control bit 1 selects 32-bit counting. When it is clear, only the low 16 bits count and the reloads are 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count pacing pulse, one clock wide per event |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_idx | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx`, combinational |
| irq | output | 1 | Level interrupt, raw flag AND enable |

## Verification
The hardest case to reach from the ports is a flag-clear write that lands in the same cycle as the step that sets the flag. The bench makes it likely by using a periodic limit of 1 at full tick rate, which sets the flag every second cycle, while clear writes arrive back to back; the reference model then checks that the set wins. A second hard case is the free-running wrap, which needs the full 16-bit range to run down. The bench spends a long tick burst on it, and uses the deferred load beforehand to show that the stored limit plays no part.

// File: rtl/ivt_pkg.sv
// Shared definitions for the interval timer channel.
// Assumes a 32-bit register port and an 8-bit control byte.
package ivt_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned IDX_W  = 3;

    // Word index decode of the register port; software depends on these values.
    typedef enum logic [IDX_W-1:0] {
        IDX_LOAD   = 3'd0,
        IDX_VALUE  = 3'd1,
        IDX_CTRL   = 3'd2,
        IDX_ICLR   = 3'd3,
        IDX_RAW    = 3'd4,
        IDX_MASKED = 3'd5,
        IDX_BGLOAD = 3'd6,
        IDX_NONE   = 3'd7
    } reg_idx_e;

    // Control byte, most significant field first.
    typedef struct packed {
        logic       run;       // bit 7
        logic       periodic;  // bit 6
        logic       irq_en;    // bit 5
        logic       spare;     // bit 4
        logic [1:0] psc;       // bits 3:2
        logic       wide;      // bit 1
        logic       single;    // bit 0
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/ivt_prescaler.sv
// Prescaler: thins the tick input to one step per 1, 16 or 256 pulses.
// Assumes PSC_W >= MID_W and that a control write restarts the phase.
module ivt_prescaler #(
    parameter int unsigned PSC_W = 8,
    parameter int unsigned MID_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic [1:0] psc_i,
    output logic       pulse_o
);

    localparam logic [PSC_W-1:0] FULL_PHASE = '1;
    localparam logic [MID_W-1:0] MID_PHASE  = '1;

    logic [PSC_W-1:0] phase_q;
    logic             wrap;

    // Phase counter: advances on each accepted tick, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i) begin
            phase_q <= '0;
        end else if (run_i && tick_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Wrap detect for the selected ratio; ratio code 3 behaves as 0.
    always_comb begin
        case (psc_i)
            2'd1:    wrap = (phase_q[MID_W-1:0] == MID_PHASE);
            2'd2:    wrap = (phase_q == FULL_PHASE);
            default: wrap = 1'b1;
        endcase
        pulse_o = run_i && tick_i && wrap;
    end

    AST_DIV256_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && psc_i == 2'd2 && !restart_i) |=> !pulse_o); // R3

endmodule

// File: rtl/ivt_counter.sv
// Down-counter with free, periodic and one-shot behaviour at two widths.
// Assumes CNT_W > NARROW_W. Bus loads take priority over a step in the same cycle.
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             ctrl_wr_i,
    input  ctrl_t            ctrl_new_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expiry_o
);

    localparam logic [CNT_W-1:0] NARROW_MASK =
        {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] step_val;
    logic [CNT_W-1:0] count_d;
    logic             free_mode;

    // Reload target: full range when free running, else the masked limit.
    function automatic logic [CNT_W-1:0] reload_of(input ctrl_t c, input logic [CNT_W-1:0] lim);
        logic [CNT_W-1:0] m;
        m = c.wide ? '1 : NARROW_MASK;
        if (!c.single && !c.periodic) begin
            return m;
        end
        return lim & m;
    endfunction

    // Width mask, masked count and the value after one step.
    always_comb begin
        mask      = ctrl_i.wide ? '1 : NARROW_MASK;
        free_mode = !ctrl_i.single && !ctrl_i.periodic;
        cur       = count_q & mask;
        expiry_o  = step_i && (cur == ONE);
        if (cur == '0) begin
            step_val = ctrl_i.single ? count_q : reload_of(ctrl_i, limit_i);
        end else begin
            step_val = cur - ONE;
        end
    end

    // Next-count select: immediate load, enabling control write, step, hold.
    always_comb begin
        if (load_wr_i) begin
            count_d = reload_of(ctrl_i, load_val_i);
        end else if (ctrl_wr_i && ctrl_new_i.run) begin
            count_d = reload_of(ctrl_new_i, limit_i);
        end else if (step_i) begin
            count_d = step_val;
        end else begin
            count_d = count_q;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= NARROW_MASK;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ctrl_i.single && cur == '0 && !load_wr_i && !ctrl_wr_i)
        |=> $stable(count_q)); // R6

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && free_mode && cur == '0 && !load_wr_i && !ctrl_wr_i)
        |=> (count_q == $past(mask))); // R4

endmodule

// File: rtl/ivt_regs.sv
// Register file: decodes the register port and holds control, limit and the
// raw flag, with the read mux. Assumes a single-cycle write strobe and that
// reads are combinational on the index.
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              expiry_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic              load_wr_o,
    output logic              ctrl_wr_o,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] limit_q;
    logic             raw_q;
    logic             wr;
    logic             bg_wr;
    logic             clr_wr;

    // Write strobe decode per index.
    always_comb begin
        wr        = sel_i && we_i;
        load_wr_o = wr && (idx_i == IDX_LOAD);
        bg_wr     = wr && (idx_i == IDX_BGLOAD);
        ctrl_wr_o = wr && (idx_i == IDX_CTRL);
        clr_wr    = wr && (idx_i == IDX_ICLR);
    end

    // Control byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
        end else if (ctrl_wr_o) begin
            ctrl_q <= ctrl_t'(wdata_i[7:0]);
        end
    end

    // Limit register, shared by immediate and deferred loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (load_wr_o || bg_wr) begin
            limit_q <= wdata_i[CNT_W-1:0];
        end
    end

    // Raw flag: set on expiry, which wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (expiry_i) begin
            raw_q <= 1'b1;
        end else if (clr_wr) begin
            raw_q <= 1'b0;
        end
    end

    // Read mux; unmapped and write-only indices return zero.
    always_comb begin
        rdata_o = '0;
        case (reg_idx_e'(idx_i))
            IDX_LOAD, IDX_BGLOAD: rdata_o[CNT_W-1:0] = limit_q;
            IDX_VALUE:            rdata_o[CNT_W-1:0] = count_i;
            IDX_CTRL:             rdata_o[7:0]       = ctrl_q;
            IDX_RAW:              rdata_o[0]         = raw_q;
            IDX_MASKED:           rdata_o[0]         = raw_q && ctrl_q.irq_en;
            default:              rdata_o            = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign limit_o = limit_q;
    assign irq_o   = raw_q && ctrl_q.irq_en;

    AST_EXPIRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        expiry_i |=> raw_q); // R7

    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expiry_i) |=> !raw_q); // R8

endmodule

// File: rtl/ivt_channel.sv
// Interval timer channel top: connects the register file, prescaler and
// counter. Assumes tick_en is synchronous to clk.
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned PSC_W    = 8,
    parameter int unsigned MID_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             load_wr;
    logic             ctrl_wr;
    logic             step;
    logic             expiry;

    ivt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel),
        .we_i      (bus_we),
        .idx_i     (bus_idx),
        .wdata_i   (bus_wdata),
        .count_i   (count),
        .expiry_i  (expiry),
        .ctrl_o    (ctrl),
        .limit_o   (limit),
        .load_wr_o (load_wr),
        .ctrl_wr_o (ctrl_wr),
        .rdata_o   (bus_rdata),
        .irq_o     (irq)
    );

    ivt_prescaler #(.PSC_W(PSC_W), .MID_W(MID_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ctrl_wr),
        .run_i     (ctrl.run),
        .tick_i    (tick_en),
        .psc_i     (ctrl.psc),
        .pulse_o   (step)
    );

    ivt_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .limit_i    (limit),
        .load_wr_i  (load_wr),
        .load_val_i (bus_wdata[CNT_W-1:0]),
        .ctrl_wr_i  (ctrl_wr),
        .ctrl_new_i (ctrl_t'(bus_wdata[7:0])),
        .step_i     (step),
        .count_o    (count),
        .expiry_o   (expiry)
    );

    AST_VALUE_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_idx == IDX_VALUE && !step) |=> $stable(count)); // R9

endmodule

// File: tb/ivt_channel_bench.sv
module ivt_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_idx = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    ivt_channel u_ivt_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Reference model state
    logic [31:0] m_count = 32'h0000_FFFF;
    logic [31:0] m_limit = 32'd0;
    logic [7:0]  m_ctrl = 8'h20;
    bit          m_flag = 1'b0;
    int          m_phase = 0;

    function automatic logic [31:0] m_mask(input logic [7:0] c);
        return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] m_reload(input logic [7:0] c, input logic [31:0] lim);
        if (!c[0] && !c[6]) return m_mask(c);
        return lim & m_mask(c);
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] i);
        case (i)
            3'd0, 3'd6: return m_limit;
            3'd1:       return m_count;
            3'd2:       return {24'd0, m_ctrl};
            3'd4:       return {31'd0, m_flag};
            3'd5:       return {31'd0, m_flag & m_ctrl[5]};
            default:    return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] cur;
        logic [31:0] nxt;
        int divn;
        bit pt;
        bit ev;
        bit wr;
        if (!rst_n) begin
            m_count = 32'h0000_FFFF; m_limit = 0; m_ctrl = 8'h20; m_flag = 0; m_phase = 0;
        end else begin
            wr   = bus_sel && bus_we;
            divn = (m_ctrl[3:2] == 2'd1) ? 16 : (m_ctrl[3:2] == 2'd2) ? 256 : 1;
            pt   = m_ctrl[7] && tick_en && ((m_phase % divn) == divn - 1);
            cur  = m_count & m_mask(m_ctrl);
            ev   = pt && (cur == 32'd1);
            nxt  = m_count;
            if (pt) nxt = (cur == 0) ? (m_ctrl[0] ? m_count : m_reload(m_ctrl, m_limit)) : cur - 1;
            if (wr && bus_idx == 3'd0) nxt = m_reload(m_ctrl, bus_wdata);
            else if (wr && bus_idx == 3'd2 && bus_wdata[7]) nxt = m_reload(bus_wdata[7:0], m_limit);
            if (wr && bus_idx == 3'd2) m_phase = 0;
            else if (m_ctrl[7] && tick_en) m_phase = (m_phase + 1) % 256;
            if (ev) m_flag = 1;
            else if (wr && bus_idx == 3'd3) m_flag = 0;
            if (wr && (bus_idx == 3'd0 || bus_idx == 3'd6)) m_limit = bus_wdata;
            if (wr && bus_idx == 3'd2) m_ctrl = bus_wdata[7:0];
            m_count = nxt;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(tag, "irq", {31'd0, irq}, {31'd0, m_flag & m_ctrl[5]});
            check(tag, "rdata", bus_rdata, m_read(bus_idx));
        end
    end

    task automatic wr(input logic [2:0] i, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_idx = i; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic run(input int n, input int every);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            tick_en = ((k % every) == 0);
        end
        @(posedge clk); #1;
        tick_en = 0;
    endtask

    task automatic rd(input string req, input logic [2:0] i, input logic [31:0] exp);
        @(posedge clk); #1;
        bus_idx = i;
        @(negedge clk);
        check(req, $sformatf("read idx %0d", i), bus_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        @(negedge clk);
        check(req, "irq pin", {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values, R2 map, R9 unused index
        tag = "R1";
        rd("R1", 3'd2, 32'h20);
        rd("R1", 3'd1, 32'h0000FFFF);
        rd("R1", 3'd0, 32'd0);
        rd("R1", 3'd4, 32'd0);
        rd("R1", 3'd5, 32'd0);
        chk_irq("R1", 1'b0);
        rd("R9", 3'd7, 32'd0);
        // R11 deferred load does not restart; R4 free run ignores limit
        tag = "R4";
        wr(3'd6, 32'd5);
        rd("R2", 3'd0, 32'd5);
        rd("R2", 3'd6, 32'd5);
        rd("R11", 3'd1, 32'h0000FFFF);
        wr(3'd2, 32'hA0);
        rd("R4", 3'd1, 32'h0000FFFF);
        run(65540, 1);
        rd("R4", 3'd1, 32'h0000FFFB);
        rd("R7", 3'd4, 32'd1);
        chk_irq("R12", 1'b1);
        // R14 32-bit free run
        tag = "R14";
        wr(3'd3, 32'd0);
        wr(3'd2, 32'hA2);
        rd("R14", 3'd1, 32'hFFFFFFFF);
        run(3, 1);
        rd("R14", 3'd1, 32'hFFFFFFFC);
        rd("R8", 3'd4, 32'd0);
        // R13 enabling control write reloads; R10 immediate load; R5 periodic
        tag = "R5";
        wr(3'd2, 32'hE0);
        rd("R13", 3'd1, 32'd5);
        wr(3'd0, 32'd7);
        rd("R10", 3'd1, 32'd7);
        run(8, 1);
        rd("R5", 3'd1, 32'd7);
        rd("R7", 3'd4, 32'd1);
        tag = "R11";
        wr(3'd6, 32'd3);
        rd("R11", 3'd1, 32'd7);
        run(8, 1);
        rd("R11", 3'd1, 32'd3);
        // R13 disabling control write freezes count
        tag = "R13";
        run(1, 1);
        wr(3'd2, 32'h60);
        run(5, 1);
        rd("R13", 3'd1, 32'd2);
        rd("R2", 3'd2, 32'h60);
        // R12 masking
        tag = "R12";
        wr(3'd2, 32'h40);
        rd("R12", 3'd4, 32'd1);
        rd("R12", 3'd5, 32'd0);
        chk_irq("R12", 1'b0);
        wr(3'd2, 32'h60);
        rd("R12", 3'd5, 32'd1);
        chk_irq("R12", 1'b1);
        // R9 ignored writes
        tag = "R9";
        wr(3'd1, 32'h1234);
        rd("R9", 3'd1, 32'd2);
        wr(3'd7, 32'hFFFF);
        wr(3'd5, 32'h0);
        rd("R9", 3'd0, 32'd3);
        rd("R9", 3'd2, 32'h60);
        rd("R9", 3'd5, 32'd1);
        // R8 clear, then clear racing expiry
        tag = "R8";
        wr(3'd3, 32'd0);
        rd("R8", 3'd4, 32'd0);
        chk_irq("R8", 1'b0);
        wr(3'd0, 32'd1);
        wr(3'd2, 32'hE0);
        fork
            run(40, 1);
            begin
                repeat (12) wr(3'd3, 32'd0);
            end
        join
        // R6 one-shot hold
        tag = "R6";
        wr(3'd2, 32'h21);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd3);
        wr(3'd2, 32'hA1);
        run(10, 1);
        rd("R6", 3'd1, 32'd0);
        rd("R6", 3'd4, 32'd1);
        wr(3'd3, 32'd0);
        run(10, 1);
        rd("R6", 3'd4, 32'd0);
        rd("R6", 3'd1, 32'd0);
        wr(3'd2, 32'hA1);
        rd("R6", 3'd1, 32'd3);
        // R3 prescale ratios
        tag = "R3";
        wr(3'd2, 32'h60);
        wr(3'd0, 32'd2);
        wr(3'd2, 32'hE4);
        run(15, 1);
        rd("R3", 3'd1, 32'd2);
        run(1, 1);
        rd("R3", 3'd1, 32'd1);
        wr(3'd2, 32'hEC);
        run(1, 1);
        rd("R3", 3'd1, 32'd1);
        wr(3'd2, 32'hE8);
        run(255, 1);
        rd("R3", 3'd1, 32'd2);
        run(1, 1);
        rd("R3", 3'd1, 32'd1);
        run(2000, 3);
        wr(3'd2, 32'hE4);
        run(600, 2);
        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule